// File: doc/BRIEF.md
# Floating-Point State Initialization Unit

This block keeps the architectural state registers of a stack-based floating-point unit: control word, status word, tag word, instruction pointer, data pointer and last-opcode register. It also executes the initialize command, which returns all of them to their power-on values. The register stack contents and the arithmetic datapath sit elsewhere. Here only the tags are touched, and every tag is marked empty.

The initialize command arrives on a valid/ready channel. A flag selects the waiting form or the non-waiting form. The waiting form first checks for an unmasked exception that is still pending. If one exists, the unit raises a service request and holds the command until the exception handler returns a done pulse. The non-waiting form resets at once. When either of the emulation or task-switched control bits is set, neither form runs, and a device-not-available fault is raised instead.

Back-pressure rules: a command is consumed on a rising edge where `init_valid` and `init_ready` are both high. `init_ready` never depends on `init_valid`. `init_ready` is low from the edge after a waiting command is parked until the reset has been applied. The requester holds `init_valid` and its qualifiers steady until the command is consumed.

Top module: `fpu_state_init`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the same values as an initialize: control 16'h037F, status 0, tag 16'hFFFF, pointers and opcode 0.
- R2: After an initialize is applied, the control word reads 16'h037F: all six exception masks (bits 5:0) set, precision field 64-bit extended, rounding to nearest.
- R3: After an initialize is applied, the status word reads 0. This clears the exception flags (bits 5:0), the condition codes (bits 8, 9, 10, 14) and the stack-top field (bits 13:11).
- R4: After an initialize is applied, the tag word reads 16'hFFFF. Each of the eight 2-bit tags is 2'b11, meaning empty.
- R5: After an initialize is applied, the instruction pointer, the data pointer and the last-opcode register read 0.
- R6: A command is consumed when `init_valid` and `init_ready` are both high at a rising edge. `init_ready` is low while `busy` is high, and a request presented then has no effect.
- R7: A non-waiting command (`init_wait`=0) with `cr_em` and `cr_ts` both clear applies the reset at the consuming edge, even when an unmasked exception is pending.
- R8: An exception is pending when some status bit i in 5:0 is 1 while control bit i is 0.
- R9: A waiting command (`init_wait`=1) that is consumed while an exception is pending leaves every register unchanged. From the next cycle it holds `svc_req` and `busy` high until `svc_done` is sampled high. The reset is applied at the edge after the one that samples `svc_done`.
- R10: A waiting command that is consumed with no pending exception applies the reset at the consuming edge.
- R11: A command consumed with `cr_em` or `cr_ts` high changes no register and raises no `svc_req`. Instead it drives `dna_fault` high for exactly the one cycle after the consuming edge.
- R12: In the cycle an initialize is applied, every register write port is ignored and the defaults win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_valid | input | 1 | Initialize command present |
| init_wait | input | 1 | 1 selects the waiting form, 0 the non-waiting form |
| init_ready | output | 1 | Command can be consumed |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| svc_done | input | 1 | Exception handler has finished servicing |
| svc_req | output | 1 | Request to service the pending exception |
| busy | output | 1 | A waiting command is in progress |
| dna_fault | output | 1 | Device-not-available fault pulse |
| wr_cw_en | input | 1 | Control word write enable |
| wr_cw | input | 16 | Control word write data |
| wr_sw_en | input | 1 | Status word write enable |
| wr_sw | input | 16 | Status word write data |
| wr_tw_en | input | 1 | Tag word write enable |
| wr_tw | input | 2*NUM_REGS | Tag word write data |
| wr_ptr_en | input | 1 | Pointer and opcode write enable |
| wr_ip | input | IP_W | Instruction pointer write data |
| wr_dp | input | DP_W | Data pointer write data |
| wr_op | input | OP_W | Last-opcode write data |
| cw | output | 16 | Control word |
| sw | output | 16 | Status word |
| tw | output | 2*NUM_REGS | Tag word |
| ip | output | IP_W | Instruction pointer |
| dp | output | DP_W | Data pointer |
| opc | output | OP_W | Last opcode |

## Verification
The bench preloads control and status values that separate a masked flag from an unmasked one. A unit that ignored the masks, or tested the wrong bit, would park a command that should reset at once, or reset one that should wait. It runs pending cases through both forms, so a non-waiting form that waited would show a raised `svc_req` and stale registers. It times the reset to the exact edge after `svc_done`, so an early or a late apply shows up. It sets the two control bits singly and together, and a unit that let a faulting command through would show defaults where the preloaded values should remain. It also drives the write ports on the apply edge, so a unit that let a write win over the reset would show the written data.

// File: rtl/fpu_init_pkg.sv
package fpu_init_pkg;
  localparam logic [15:0] CW_DEFAULT = 16'h037F;
  localparam logic [1:0]  TAG_EMPTY  = 2'b11;
  localparam int          EXC_FLAGS  = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_APPLY = 2'd2
  } init_st_t;
endpackage

// File: rtl/fpu_init_ctrl.sv
module fpu_init_ctrl
  import fpu_init_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_valid,
  input  logic                 init_wait,
  input  logic                 cr_em,
  input  logic                 cr_ts,
  input  logic [EXC_FLAGS-1:0] cw_mask,
  input  logic [EXC_FLAGS-1:0] sw_flags,
  input  logic                 svc_done,
  output logic                 init_ready,
  output logic                 busy,
  output logic                 svc_req,
  output logic                 dna_fault,
  output logic                 init_apply
);
  init_st_t st_q, st_d;
  logic accept, blocked, pending, park, fault_q;

  assign init_ready = (st_q == ST_IDLE);
  assign accept     = init_valid && init_ready;
  assign blocked    = cr_em || cr_ts;
  assign pending    = |(sw_flags & ~cw_mask);
  assign park       = accept && !blocked && init_wait && pending;
  assign init_apply = (accept && !blocked && !park) || (st_q == ST_APPLY);
  assign busy       = (st_q != ST_IDLE);
  assign svc_req    = (st_q == ST_WAIT);
  assign dna_fault  = fault_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (park) st_d = ST_WAIT;
      ST_WAIT:  if (svc_done) st_d = ST_APPLY;
      ST_APPLY: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      fault_q <= accept && blocked;
    end
  end

  // R11
  fault_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && blocked) |-> !init_apply);
  // R11
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && blocked) |=> (dna_fault && !svc_req));
  // R9
  svc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    svc_req |-> !init_apply);
  // R9
  svc_release_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_req && svc_done) |=> init_apply);
  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !init_ready);
endmodule

// File: rtl/fpu_state_regs.sv
module fpu_state_regs
  import fpu_init_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IP_W     = 32,
  parameter int DP_W     = 32,
  parameter int OP_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_apply,
  input  logic                  wr_cw_en,
  input  logic [15:0]           wr_cw,
  input  logic                  wr_sw_en,
  input  logic [15:0]           wr_sw,
  input  logic                  wr_tw_en,
  input  logic [2*NUM_REGS-1:0] wr_tw,
  input  logic                  wr_ptr_en,
  input  logic [IP_W-1:0]       wr_ip,
  input  logic [DP_W-1:0]       wr_dp,
  input  logic [OP_W-1:0]       wr_op,
  output logic [15:0]           cw,
  output logic [15:0]           sw,
  output logic [2*NUM_REGS-1:0] tw,
  output logic [IP_W-1:0]       ip,
  output logic [DP_W-1:0]       dp,
  output logic [OP_W-1:0]       opc
);
  localparam int TW_W = 2 * NUM_REGS;

  logic load_dflt;
  assign load_dflt = rst || init_apply;

  always_ff @(posedge clk) begin
    if (load_dflt) begin
      cw  <= CW_DEFAULT;
      sw  <= '0;
      ip  <= '0;
      dp  <= '0;
      opc <= '0;
    end else begin
      if (wr_cw_en) cw <= wr_cw;
      if (wr_sw_en) sw <= wr_sw;
      if (wr_ptr_en) begin
        ip  <= wr_ip;
        dp  <= wr_dp;
        opc <= wr_op;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_tag
    logic [1:0] tag_q;
    always_ff @(posedge clk) begin
      if (load_dflt)     tag_q <= TAG_EMPTY;
      else if (wr_tw_en) tag_q <= wr_tw[2*g +: 2];
    end
    assign tw[2*g +: 2] = tag_q;
  end

  // R1
  hw_reset_dflt_chk: assert property (@(posedge clk)
    rst |=> (cw == CW_DEFAULT && sw == '0 && tw == {TW_W{1'b1}}));
  // R2
  init_cw_chk: assert property (@(posedge clk) disable iff (rst)
    init_apply |=> cw == CW_DEFAULT);
  // R3
  init_sw_chk: assert property (@(posedge clk) disable iff (rst)
    init_apply |=> sw == '0);
  // R4
  init_tw_chk: assert property (@(posedge clk) disable iff (rst)
    init_apply |=> tw == {TW_W{1'b1}});
  // R5
  init_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    init_apply |=> (ip == '0 && dp == '0 && opc == '0));
endmodule

// File: rtl/fpu_state_init.sv
module fpu_state_init
  import fpu_init_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IP_W     = 32,
  parameter int DP_W     = 32,
  parameter int OP_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_valid,
  input  logic                  init_wait,
  output logic                  init_ready,
  input  logic                  cr_em,
  input  logic                  cr_ts,
  input  logic                  svc_done,
  output logic                  svc_req,
  output logic                  busy,
  output logic                  dna_fault,
  input  logic                  wr_cw_en,
  input  logic [15:0]           wr_cw,
  input  logic                  wr_sw_en,
  input  logic [15:0]           wr_sw,
  input  logic                  wr_tw_en,
  input  logic [2*NUM_REGS-1:0] wr_tw,
  input  logic                  wr_ptr_en,
  input  logic [IP_W-1:0]       wr_ip,
  input  logic [DP_W-1:0]       wr_dp,
  input  logic [OP_W-1:0]       wr_op,
  output logic [15:0]           cw,
  output logic [15:0]           sw,
  output logic [2*NUM_REGS-1:0] tw,
  output logic [IP_W-1:0]       ip,
  output logic [DP_W-1:0]       dp,
  output logic [OP_W-1:0]       opc
);
  logic init_apply;

  fpu_init_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .init_valid (init_valid),
    .init_wait  (init_wait),
    .cr_em      (cr_em),
    .cr_ts      (cr_ts),
    .cw_mask    (cw[EXC_FLAGS-1:0]),
    .sw_flags   (sw[EXC_FLAGS-1:0]),
    .svc_done   (svc_done),
    .init_ready (init_ready),
    .busy       (busy),
    .svc_req    (svc_req),
    .dna_fault  (dna_fault),
    .init_apply (init_apply)
  );

  fpu_state_regs #(
    .NUM_REGS (NUM_REGS),
    .IP_W     (IP_W),
    .DP_W     (DP_W),
    .OP_W     (OP_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .init_apply (init_apply),
    .wr_cw_en   (wr_cw_en),
    .wr_cw      (wr_cw),
    .wr_sw_en   (wr_sw_en),
    .wr_sw      (wr_sw),
    .wr_tw_en   (wr_tw_en),
    .wr_tw      (wr_tw),
    .wr_ptr_en  (wr_ptr_en),
    .wr_ip      (wr_ip),
    .wr_dp      (wr_dp),
    .wr_op      (wr_op),
    .cw         (cw),
    .sw         (sw),
    .tw         (tw),
    .ip         (ip),
    .dp         (dp),
    .opc        (opc)
  );
endmodule

// File: tb/fpu_state_init_test.sv
module fpu_state_init_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_valid = 1'b0, init_wait = 1'b0, cr_em = 1'b0, cr_ts = 1'b0, svc_done = 1'b0;
  logic        init_ready, svc_req, busy, dna_fault;
  logic        wr_cw_en = 1'b0, wr_sw_en = 1'b0, wr_tw_en = 1'b0, wr_ptr_en = 1'b0;
  logic [15:0] wr_cw = '0, wr_sw = '0, wr_tw = '0;
  logic [31:0] wr_ip = '0, wr_dp = '0;
  logic [10:0] wr_op = '0;
  logic [15:0] cw, sw, tw;
  logic [31:0] ip, dp;
  logic [10:0] opc;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpu_state_init uut (
    .clk(clk), .rst(rst), .init_valid(init_valid), .init_wait(init_wait),
    .init_ready(init_ready), .cr_em(cr_em), .cr_ts(cr_ts), .svc_done(svc_done),
    .svc_req(svc_req), .busy(busy), .dna_fault(dna_fault),
    .wr_cw_en(wr_cw_en), .wr_cw(wr_cw), .wr_sw_en(wr_sw_en), .wr_sw(wr_sw),
    .wr_tw_en(wr_tw_en), .wr_tw(wr_tw), .wr_ptr_en(wr_ptr_en),
    .wr_ip(wr_ip), .wr_dp(wr_dp), .wr_op(wr_op),
    .cw(cw), .sw(sw), .tw(tw), .ip(ip), .dp(dp), .opc(opc)
  );

  // {em, ts, wait_form, cw_pre, sw_pre, exp_fault, exp_park}
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h0000, 16'h0001, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h037F, 16'h003F, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h0000, 16'h0004, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'h0000, 16'h7F00, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h0000, 16'h0001, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 16'h037F, 16'h0000, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h0020, 16'h0020, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 16'h001F, 16'h0020, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_defaults(input string tag);
    chk(cw == 16'h037F, {tag, " R2 cw"}, cw, 16'h037F);
    chk(sw == 16'h0000, {tag, " R3 sw"}, sw, 0);
    chk(tw == 16'hFFFF, {tag, " R4 tw"}, tw, 16'hFFFF);
    chk(ip == 0 && dp == 0 && opc == 0, {tag, " R5 ptrs"}, {ip, dp}, 0);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic preload(input logic [15:0] c, input logic [15:0] s);
    @(negedge clk);
    wr_cw_en = 1; wr_cw = c; wr_sw_en = 1; wr_sw = s; wr_tw_en = 1; wr_tw = 16'h1B1B;
    wr_ptr_en = 1; wr_ip = 32'hCAFE_0010; wr_dp = 32'h0000_BEEF; wr_op = 11'h5A5;
    step();
    @(negedge clk);
    wr_cw_en = 0; wr_sw_en = 0; wr_tw_en = 0; wr_ptr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    @(negedge clk); rst = 0;
    // R1 reset state
    chk_defaults("R1 reset");
    chk(init_ready && !busy && !svc_req && !dna_fault, "R1 ctrl idle",
        {init_ready, busy, svc_req, dna_fault}, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      logic em, ts, wf, ef, ep;
      logic [15:0] c, s;
      {em, ts, wf, c, s, ef, ep} = VEC[i];
      preload(c, s);
      init_valid = 1; init_wait = wf; cr_em = em; cr_ts = ts;
      step();
      @(negedge clk); init_valid = 0; cr_em = 0; cr_ts = 0;
      if (ef) begin
        // R11 fault blocks the reset
        chk(dna_fault == 1'b1, "R11 fault pulse", dna_fault, 1);
        chk(cw == c && sw == s && tw == 16'h1B1B && !svc_req, "R11 regs kept",
            {cw, sw, tw}, {c, s, 16'h1B1B});
        step();
        chk(dna_fault == 1'b0, "R11 single pulse", dna_fault, 0);
      end else if (ep) begin
        // R8 R9 parked on pending exception
        chk(svc_req && busy && !init_ready, "R9 parked",
            {svc_req, busy, init_ready}, 3'b110);
        chk(cw == c && sw == s && ip == 32'hCAFE_0010, "R9 regs held", {cw, sw}, {c, s});
        init_valid = 1;  // R6 request while busy is ignored
        step(); step();
        @(negedge clk); init_valid = 0;
        chk(svc_req && cw == c && sw == s, "R6 still waiting", {cw, sw}, {c, s});
        svc_done = 1;
        step();
        @(negedge clk); svc_done = 0;
        chk(cw == c && !svc_req && busy, "R9 not yet applied", cw, c);
        step();
        chk_defaults("R9 after service");
        chk(!busy && init_ready, "R6 ready again", {busy, init_ready}, 2'b01);
      end else begin
        // R7 R10 R8 immediate reset
        chk(!svc_req && !dna_fault, wf ? "R10 no park" : "R7 no park", svc_req, 0);
        chk_defaults(wf ? "R10 immediate" : "R7 immediate");
      end
      step();
      chk(!busy && !svc_req, "R6 idle after vector", {busy, svc_req}, 0);
    end

    // R12 writes on the apply edge lose
    preload(16'h0000, 16'h0001);
    wr_cw_en = 1; wr_cw = 16'h0ABC; wr_sw_en = 1; wr_sw = 16'h1234;
    wr_tw_en = 1; wr_tw = 16'h0000; wr_ptr_en = 1;
    init_valid = 1; init_wait = 0;
    step();
    @(negedge clk);
    init_valid = 0; wr_cw_en = 0; wr_sw_en = 0; wr_tw_en = 0; wr_ptr_en = 0;
    chk(cw == 16'h037F, "R12 cw write ignored", cw, 16'h037F);
    chk(sw == 0 && tw == 16'hFFFF && ip == 0, "R12 other writes ignored", {sw, tw}, {16'h0, 16'hFFFF});

    // R1 hardware reset mid-run
    preload(16'h0C00, 16'h3842);
    rst = 1;
    step();
    @(negedge clk); rst = 0;
    chk_defaults("R1 midrun");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule